// File: doc/BRIEF.md
# Scanline Sprite Evaluation Unit

This block picks, ahead of each scanline, which sprites from an attribute list will appear on that line. A sequencer presents the list one entry per clock through a valid strobe. Each entry carries a sprite number and a vertical position. The unit works out which row of the sprite falls on the coming line. If that row lies inside the sprite, the unit stores the sprite number and the row in the next free slot of a small table, which the pattern fetch stage reads later.

The unit also keeps two fields of the status byte. The first is a sticky overflow flag, set when a visible sprite finds no free slot. The second is a five-bit sprite number field, which follows every examined entry until the overflow flag freezes it. A pulse on `line_start` clears the slot table and re-arms the scan for a new line. In 192-line mode a vertical position of 208 ends the list early.

The control is a two-state machine. In `ST_SCAN` entries are evaluated and may be stored. A terminator moves it to `ST_HALT` (transition SCAN→HALT). In `ST_HALT` entries are never stored. A `line_start` pulse moves it from either state back to `ST_SCAN` (transitions HALT→SCAN and SCAN→SCAN). Reset enters `ST_SCAN`.

Top module: `sprite_line_eval`

## Requirements
- R1: After reset the slot count is 0, the overflow flag is 0, the number field is 0, the unit is not halted and every slot holds number 0 and row 0.
- R2: For an accepted entry with vertical position Y, let A = (screen_row+1) mod total_lines and D = (A − ((Y+1) mod 256)) mod 256. The sprite is visible when D is less than the sprite height. The calculation wraps, so on the last line of the frame A is 0.
- R3: The sprite height is 8. It is 16 when `size16` is 1, 16 when only `magnify` is 1, and 32 when both are 1.
- R4: The row stored for a visible sprite is D when `magnify` is 0, and D shifted right by one when `magnify` is 1.
- R5: The slot limit is 4 when `ext_mode` is 0 and 8 when it is 1. A visible sprite met when the count equals the limit sets the overflow flag and is not stored.
- R6: While the overflow flag is 0, every accepted entry writes its number into the number field. This includes entries ignored after a terminator and the entry that sets overflow. While the overflow flag is 1, the field does not change.
- R7: The overflow flag stays at 1 until a `status_clr` pulse clears it.
- R8: With `term_en` at 1, Y = 208 halts the line and stores nothing. No later entry on that line is stored. With `term_en` at 0, Y = 208 is an ordinary position.
- R9: `line_start` clears the count, the halt and all slots, and leaves the status fields unchanged. If an entry is presented in the same cycle, the entry is dropped.
- R10: Slot k, counting from 0, holds the number and row of the (k+1)-th stored sprite of the line. Results are registered and appear one cycle after the entry is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Begins evaluation for a new line |
| entry_valid | input | 1 | An entry is presented this cycle |
| entry_num | input | 5 | Sprite number of the entry |
| entry_y | input | 8 | Vertical position of the entry |
| screen_row | input | 9 | Current screen row |
| total_lines | input | 9 | Lines per frame |
| size16 | input | 1 | 16×16 sprites |
| magnify | input | 1 | Doubled sprites |
| ext_mode | input | 1 | Extended tile mode (8 slots) |
| term_en | input | 1 | Enables the Y = 208 terminator |
| status_clr | input | 1 | Clears the overflow flag (status read) |
| slot_count | output | 4 | Number of stored sprites |
| slot_nums | output | 40 | Sprite numbers, slot k at bits 5k+4:5k |
| slot_rows | output | 40 | Sprite rows, slot k at bits 5k+4:5k |
| halted | output | 1 | A terminator has been seen on this line |
| stat_ovf | output | 1 | Sticky overflow flag |
| stat_num | output | 5 | Number field of the status byte |

## Verification
The hardest point to reach is a full slot table followed by a visible sprite, with invisible entries placed before and after it. Those entries show that the number field freezes at the overflowing sprite and then tracks again once `status_clr` is pulsed. To get there, the stimulus chooses vertical positions that give known row offsets, and fills the table in both the four-slot and the eight-slot mode. Further runs cover the last frame line, so the row calculation wraps to 0, a terminator followed by a visible sprite, and a `line_start` presented in the same cycle as an entry.

// File: rtl/sprev_pkg.sv
package sprev_pkg;
    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_HALT = 1'b1
    } sprev_state_t;
endpackage

// File: rtl/sprev_match.sv
module sprev_match #(
    parameter int ROW_W  = 9,
    parameter int Y_W    = 8,
    parameter int BASE_H = 8,
    parameter int OUT_W  = 5
) (
    input  logic [ROW_W-1:0] screen_row,
    input  logic [ROW_W-1:0] total_lines,
    input  logic [Y_W-1:0]   y_pos,
    input  logic             size16,
    input  logic             magnify,
    output logic             hit,
    output logic [OUT_W-1:0] row
);
    localparam int H_W = $clog2(BASE_H * 4) + 1;

    logic [ROW_W:0]   next_row;
    logic [Y_W-1:0]   line_pos;
    logic [Y_W-1:0]   y_plus;
    logic [Y_W-1:0]   diff;
    logic [H_W-1:0]   height;

    always_comb begin
        next_row = {1'b0, screen_row} + 1'b1;
        if (next_row >= {1'b0, total_lines})
            line_pos = '0;
        else
            line_pos = next_row[Y_W-1:0];
        y_plus = y_pos + 1'b1;
        diff   = line_pos - y_plus;
        height = H_W'(BASE_H);
        if (size16)
            height = height << 1;
        if (magnify)
            height = height << 1;
        hit = ({{(H_W > Y_W ? H_W - Y_W : 0){1'b0}}, diff} < (Y_W + H_W)'(height));
        if (magnify)
            row = OUT_W'(diff >> 1);
        else
            row = OUT_W'(diff);
    end
endmodule

// File: rtl/sprev_slots.sv
module sprev_slots #(
    parameter int SLOTS = 8,
    parameter int NUM_W = 5,
    parameter int RW    = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [$clog2(SLOTS)-1:0] wr_ptr,
    input  logic [NUM_W-1:0]       wr_num,
    input  logic [RW-1:0]          wr_row,
    output logic [SLOTS*NUM_W-1:0] nums,
    output logic [SLOTS*RW-1:0]    rows
);
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [NUM_W-1:0] num_q;
        logic [RW-1:0]    row_q;
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                num_q <= '0;
                row_q <= '0;
            end else if (wr_en && wr_ptr == k) begin
                num_q <= wr_num;
                row_q <= wr_row;
            end
        end
        assign nums[k*NUM_W +: NUM_W] = num_q;
        assign rows[k*RW +: RW]       = row_q;
    end

    assert_slot_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (nums == '0 && rows == '0));
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval
    import sprev_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int LEGACY = 4,
    parameter int NUM_W  = 5,
    parameter int Y_W    = 8,
    parameter int ROW_W  = 9,
    parameter int RW     = 5,
    parameter int TERM_Y = 208
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic                   entry_valid,
    input  logic [NUM_W-1:0]       entry_num,
    input  logic [Y_W-1:0]         entry_y,
    input  logic [ROW_W-1:0]       screen_row,
    input  logic [ROW_W-1:0]       total_lines,
    input  logic                   size16,
    input  logic                   magnify,
    input  logic                   ext_mode,
    input  logic                   term_en,
    input  logic                   status_clr,
    output logic [$clog2(SLOTS+1)-1:0] slot_count,
    output logic [SLOTS*NUM_W-1:0] slot_nums,
    output logic [SLOTS*RW-1:0]    slot_rows,
    output logic                   halted,
    output logic                   stat_ovf,
    output logic [NUM_W-1:0]       stat_num
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int PTR_W = $clog2(SLOTS);

    sprev_state_t state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] limit;
    logic             accept, is_term, hit, store, ovf_set;
    logic [RW-1:0]    row;

    sprev_match #(.ROW_W(ROW_W), .Y_W(Y_W), .BASE_H(8), .OUT_W(RW)) u_match (
        .screen_row (screen_row),
        .total_lines(total_lines),
        .y_pos      (entry_y),
        .size16     (size16),
        .magnify    (magnify),
        .hit        (hit),
        .row        (row)
    );

    always_comb begin
        accept  = entry_valid && !line_start;
        is_term = term_en && (entry_y == Y_W'(TERM_Y));
        limit   = ext_mode ? CNT_W'(SLOTS) : CNT_W'(LEGACY);
        store   = accept && state_q == ST_SCAN && !is_term && hit && count_q < limit;
        ovf_set = accept && state_q == ST_SCAN && !is_term && hit && count_q >= limit;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: if (line_start)          state_d = ST_SCAN;
                     else if (accept && is_term) state_d = ST_HALT;
            ST_HALT: if (line_start)          state_d = ST_SCAN;
            default:                          state_d = ST_SCAN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    // outputs: count and status fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            stat_ovf <= 1'b0;
            stat_num <= '0;
        end else begin
            if (line_start)
                count_q <= '0;
            else if (store)
                count_q <= count_q + 1'b1;
            if (accept && !stat_ovf)
                stat_num <= entry_num;
            if (ovf_set)
                stat_ovf <= 1'b1;
            else if (status_clr)
                stat_ovf <= 1'b0;
        end
    end

    sprev_slots #(.SLOTS(SLOTS), .NUM_W(NUM_W), .RW(RW)) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (line_start),
        .wr_en (store),
        .wr_ptr(count_q[PTR_W-1:0]),
        .wr_num(entry_num),
        .wr_row(row),
        .nums  (slot_nums),
        .rows  (slot_rows)
    );

    assign slot_count = count_q;
    assign halted     = (state_q == ST_HALT);

    assert_full_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !halted && !is_term && hit && count_q == limit) |=> (stat_ovf && $stable(slot_count)));
    assert_num_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovf && !status_clr) |=> $stable(stat_num));
    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovf && !status_clr) |=> stat_ovf);
    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !line_start) |=> (halted && $stable(slot_count)));
    assert_line_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (slot_count == '0 && !halted));
endmodule

// File: tb/sprite_line_eval_test.sv
module sprite_line_eval_test;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0, entry_valid = 1'b0, status_clr = 1'b0;
    logic [4:0]  entry_num = '0;
    logic [7:0]  entry_y = '0;
    logic [8:0]  screen_row = 9'd10, total_lines = 9'd262;
    logic        size16 = 1'b0, magnify = 1'b0, ext_mode = 1'b0, term_en = 1'b0;
    logic [3:0]  slot_count;
    logic [39:0] slot_nums, slot_rows;
    logic        halted, stat_ovf;
    logic [4:0]  stat_num;

    always #(PER/2) clk = ~clk;

    sprite_line_eval uut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .entry_valid(entry_valid),
        .entry_num(entry_num), .entry_y(entry_y), .screen_row(screen_row),
        .total_lines(total_lines), .size16(size16), .magnify(magnify),
        .ext_mode(ext_mode), .term_en(term_en), .status_clr(status_clr),
        .slot_count(slot_count), .slot_nums(slot_nums), .slot_rows(slot_rows),
        .halted(halted), .stat_ovf(stat_ovf), .stat_num(stat_num)
    );

    typedef struct {
        int          cnt;
        logic        ovf;
        logic [4:0]  num;
        logic        halt;
        logic [39:0] nums;
        logic [39:0] rows;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0, bad = 0;
    bit done = 0;

    int         m_cnt = 0;
    logic       m_ovf = 0, m_halt = 0;
    logic [4:0] m_num = 0;
    logic [39:0] m_nums = '0, m_rows = '0;

    function automatic void push(string tag);
        item_t it;
        it.cnt = m_cnt; it.ovf = m_ovf; it.num = m_num; it.halt = m_halt;
        it.nums = m_nums; it.rows = m_rows; it.tag = tag;
        q.push_back(it);
    endfunction

    task automatic compare(item_t it);
        total++;
        if (slot_count != it.cnt[3:0] || stat_ovf != it.ovf || stat_num != it.num ||
            halted != it.halt || slot_nums != it.nums || slot_rows != it.rows) begin
            bad++;
            $display("FAIL %s: got cnt=%0d ovf=%0b num=%0d halt=%0b nums=%h rows=%h exp cnt=%0d ovf=%0b num=%0d halt=%0b nums=%h rows=%h",
                     it.tag, slot_count, stat_ovf, stat_num, halted, slot_nums, slot_rows,
                     it.cnt, it.ovf, it.num, it.halt, it.nums, it.rows);
        end
    endtask

    // monitor: pops one expected item per cycle after the edge that produced it
    initial forever begin
        @(posedge clk);
        #(PER/4);
        if (q.size() > 0) compare(q.pop_front());
    end

    task automatic send(input int num, input int y, input string tag);
        int a, d, h, lim;
        @(negedge clk);
        entry_valid = 1'b1; entry_num = 5'(num); entry_y = 8'(y);
        if (!m_ovf) m_num = 5'(num);
        if (!m_halt) begin
            if (term_en && y == 208) m_halt = 1;
            else begin
                a = (int'(screen_row) + 1) % int'(total_lines);
                d = (a - ((y + 1) % 256) + 256) % 256;
                h = 8 * (size16 ? 2 : 1) * (magnify ? 2 : 1);
                lim = ext_mode ? 8 : 4;
                if (d < h) begin
                    if (m_cnt == lim) m_ovf = 1;
                    else begin
                        m_nums[m_cnt*5 +: 5] = 5'(num);
                        m_rows[m_cnt*5 +: 5] = 5'(magnify ? d / 2 : d);
                        m_cnt++;
                    end
                end
            end
        end
        push(tag);
        @(negedge clk);
        entry_valid = 1'b0;
    endtask

    task automatic new_line(input bit with_entry, input string tag);
        @(negedge clk);
        line_start = 1'b1;
        if (with_entry) begin entry_valid = 1'b1; entry_num = 5'd31; entry_y = 8'd10; end
        m_cnt = 0; m_halt = 0; m_nums = '0; m_rows = '0;
        push(tag);
        @(negedge clk);
        line_start = 1'b0; entry_valid = 1'b0;
    endtask

    task automatic clear_status(input string tag);
        @(negedge clk);
        status_clr = 1'b1;
        m_ovf = 0;
        push(tag);
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    initial begin
        #(PER * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        total++;
        if (slot_count != 0 || stat_ovf || stat_num != 0 || halted || slot_nums != 0 || slot_rows != 0) begin
            bad++;
            $display("FAIL R1: got cnt=%0d ovf=%0b num=%0d halt=%0b exp all zero", slot_count, stat_ovf, stat_num, halted);
        end

        // legacy 8x8 line, row 10: R2 R3 R10
        new_line(0, "R9 clear");
        send(1, 5,   "R2 hit d=5 slot0");
        send(2, 2,   "R3 d=8 outside height 8");
        send(3, 10,  "R10 d=0 slot1");
        send(4, 3,   "R2 d=7 slot2");
        send(5, 250, "R2 far miss");
        send(6, 9,   "R10 slot3 fills legacy");
        send(7, 4,   "R5 fifth visible sets overflow");
        send(8, 250, "R6 number frozen");
        send(9, 6,   "R7 overflow sticky");
        clear_status("R7 clear");
        send(10, 250, "R6 number tracks again");

        // size16: R3
        size16 = 1'b1;
        new_line(0, "R9 new line keeps status");
        send(11, 0,   "R3 d=10 within 16");
        send(12, 250, "R3 d=16 outside 16");
        // magnify + size16 at row 30: R4
        magnify = 1'b1; screen_row = 9'd30;
        new_line(0, "R9 line");
        send(13, 10,  "R4 d=20 stored 10");
        send(14, 255, "R4 d=31 stored 15");
        send(15, 29,  "R4 d=1 stored 0");
        // magnify alone: height 16
        size16 = 1'b0;
        new_line(0, "R9 line");
        send(16, 14,  "R3 magnify only d=16 miss");
        send(17, 16,  "R4 magnify only d=14 stored 7");

        // extended mode, 8 slots: R5
        magnify = 1'b0; ext_mode = 1'b1; screen_row = 9'd10;
        new_line(0, "R9 line");
        for (int k = 0; k < 8; k++) send(k + 1, 3 + k, "R5 ext fill");
        send(20, 10, "R5 ninth sets overflow");
        send(21, 5,  "R6 frozen after ext overflow");
        clear_status("R7 clear");

        // terminator: R8
        ext_mode = 1'b0; term_en = 1'b1;
        new_line(0, "R9 line");
        send(22, 5,   "R8 before terminator");
        send(23, 208, "R8 terminator halts");
        send(24, 6,   "R8 visible after halt not stored, R6 num tracks");
        term_en = 1'b0;
        new_line(0, "R9 clears halt");
        send(25, 208, "R8 208 ordinary when disabled");
        send(26, 7,   "R8 still scanning");

        // wrap on last line: R2
        screen_row = 9'd261;
        new_line(0, "R9 line");
        send(27, 255, "R2 wrap d=0");
        send(28, 250, "R2 wrap d=5");
        send(29, 5,   "R2 wrap d=250 miss");

        // simultaneous line_start and entry: R9
        screen_row = 9'd10;
        new_line(1, "R9 entry dropped with line_start");

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule